// File: doc/BRIEF.md
# PUF Response Quality Metrics Unit

This block measures the quality of physically unclonable function responses. Each transaction presents two equal-width response words, a reference and a sample. For every pair the unit counts the differing bits (Hamming distance), the ones in the sample (Hamming weight), and the ones in the bitwise AND and the bitwise OR of the two words. The last two counts are the intersection and union sizes behind a Jaccard index. All four counts come from pipelined population-count trees and share one fixed latency.

The per-pair counts are also summed into running accumulators, together with a pair counter. When the host presents pairs from the same chip at different times, the distance sum gives the intra-chip distance and so the reliability. When it presents pairs from different chips, the same sum gives the inter-chip distance and so the uniqueness. The weight sum gives uniformity. A finalize pulse copies the totals and runs one sequential divider three times. It reports the average distance, the average weight and the Jaccard index as fixed-point percentages with FRAC fraction bits. Reliability is derived from the distance result. A clear pulse restarts the accumulation.

Top module: `puf_metrics`

## Requirements
- R1: For each pair accepted on `in_valid`, `res_hd` equals the number of bit positions in which `ref_word` and `smp_word` differ. It is valid with `res_valid` high two cycles after the pair was sampled.
- R2: In the same cycle, `res_hw` equals the number of ones in `smp_word`.
- R3: In the same cycle, `res_inter` is the count of ones in `ref_word & smp_word` and `res_union` is the count of ones in `ref_word | smp_word`.
- R4: One cycle after a result is valid, `sum_hd`, `sum_hw`, `sum_inter` and `sum_union` have each grown by that result's counts, and `pair_cnt` has grown by one.
- R5: Once `pair_cnt` has reached MAX_PAIRS, further results change neither the sums nor the count.
- R6: A `clr` pulse zeroes all sums and `pair_cnt` on the next edge. Pairs still in the count pipeline at that edge are discarded.
- R7: A `fin` pulse while `busy` is low raises `busy`. When `done` pulses and `busy` falls, `hd_pct` = floor(sum_hd·100·2^FRAC / (pair_cnt·N)) and `hw_pct` = floor(sum_hw·100·2^FRAC / (pair_cnt·N)). Both use the totals at the `fin` edge.
- R8: With the same timing, `jac_pct` = floor(sum_inter·100·2^FRAC / sum_union). If sum_union was zero, `jac_pct` is 0 and `union_zero` is 1; otherwise `union_zero` is 0.
- R9: `rel_pct` = 100·2^FRAC − `hd_pct`. If `pair_cnt` was zero at `fin`, `hd_pct`, `hw_pct` and `rel_pct` are 0 and `empty_flag` is 1. `empty_flag` is also 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Zero accumulators and flush the count pipeline |
| in_valid | input | 1 | A response pair is present |
| ref_word | input | N | Reference response |
| smp_word | input | N | Sample response |
| res_valid | output | 1 | Per-pair counts are valid |
| res_hd | output | clog2(N+1) | Hamming distance of the pair |
| res_hw | output | clog2(N+1) | Hamming weight of the sample |
| res_inter | output | clog2(N+1) | Ones in the AND of the pair |
| res_union | output | clog2(N+1) | Ones in the OR of the pair |
| sum_hd | output | clog2(MAX_PAIRS·N+1) | Accumulated distance |
| sum_hw | output | clog2(MAX_PAIRS·N+1) | Accumulated weight |
| sum_inter | output | clog2(MAX_PAIRS·N+1) | Accumulated intersection |
| sum_union | output | clog2(MAX_PAIRS·N+1) | Accumulated union |
| pair_cnt | output | clog2(MAX_PAIRS+1) | Pairs accumulated |
| fin | input | 1 | Start the ratio computation |
| busy | output | 1 | Ratio computation running |
| done | output | 1 | One-cycle pulse when the ratios are ready |
| hd_pct | output | 7+FRAC | Average distance percentage, fixed point |
| hw_pct | output | 7+FRAC | Uniformity percentage, fixed point |
| jac_pct | output | 7+FRAC | Jaccard percentage, fixed point |
| rel_pct | output | 7+FRAC | Reliability percentage, fixed point |
| empty_flag | output | 1 | No pairs were accumulated at finalize |
| union_zero | output | 1 | Union sum was zero at finalize |

## Verification
The bench builds the unit with N=8, CHUNK=4, MAX_PAIRS=6 and FRAC=4. An 8-bit word lets every one of the 65,536 reference and sample combinations stream through the count trees back to back. Both chunks of the two-level tree are then used, and each count is checked at its fixed latency. A cap of six pairs brings saturation within a few cycles. The small accumulator and divider widths let the bench recompute the floor-rounded percentages exactly for a mixed set of pairs, for an all-zero pair (union of zero) and for an empty run.

// File: rtl/puf_metrics_pkg.sv
// Package: shared types for the PUF metrics unit.
// Assumes: nothing beyond IEEE 1800-2017.
package puf_metrics_pkg;

    // Finalize sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } fin_state_t;

    // Index of each per-pair count tree, also used to select the ratio
    localparam int unsigned IDX_HD    = 0;
    localparam int unsigned IDX_HW    = 1;
    localparam int unsigned IDX_INTER = 2;
    localparam int unsigned IDX_UNION = 3;
    localparam int unsigned NUM_TREES = 4;

endpackage

// File: rtl/popcnt_pipe.sv
// Module: popcnt_pipe
// Counts the ones in a W-bit word with a two-stage pipeline. Stage one counts
// each CHUNK-bit slice and stage two adds the slice counts. Latency is two
// edges and every edge accepts a new word.
// Assumes: CHUNK >= 1; the top bits of the last slice are padded with zeros.
module popcnt_pipe #(
    parameter int W     = 16,
    parameter int CHUNK = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           bits_in,
    output logic [$clog2(W+1)-1:0] count_out
);
    localparam int NCH = (W + CHUNK - 1) / CHUNK;
    localparam int PW  = NCH * CHUNK;
    localparam int CW  = $clog2(CHUNK + 1);
    localparam int OW  = $clog2(W + 1);

    logic [PW-1:0] padded;
    logic [CW-1:0] part_q [NCH];
    logic [OW-1:0] total;

    assign padded = PW'(bits_in);

    for (genvar c = 0; c < NCH; c++) begin : g_slice
        logic [CW-1:0] part_c;

        // Count the ones of one slice
        always_comb begin
            part_c = '0;
            for (int b = 0; b < CHUNK; b++) begin
                part_c = part_c + CW'(padded[c*CHUNK + b]);
            end
        end

        // Stage one register for this slice
        always_ff @(posedge clk) begin
            if (!rst_n) part_q[c] <= '0;
            else        part_q[c] <= part_c;
        end
    end

    // Add the slice counts
    always_comb begin
        total = '0;
        for (int c = 0; c < NCH; c++) begin
            total = total + OW'(part_q[c]);
        end
    end

    // Stage two register
    always_ff @(posedge clk) begin
        if (!rst_n) count_out <= '0;
        else        count_out <= total;
    end

    assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count_out <= OW'(W));

endmodule

// File: rtl/seq_divider.sv
// Module: seq_divider
// Restoring unsigned divider that produces one quotient bit per cycle.
// A start pulse while idle loads the operands. NUM_W cycles later done pulses
// and quo holds floor(num/den).
// Assumes: den is held stable while busy; the caller handles den == 0.
module seq_divider #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int IT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] numsh;
    logic [IT_W-1:0]  iter;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    // Trial subtraction for the next quotient bit
    always_comb begin
        trial = {rem, numsh[NUM_W-1]};
        fits  = trial >= {1'b0, den};
        diff  = trial - {1'b0, den};
    end

    // Iteration state, quotient shift and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            iter  <= '0;
            rem   <= '0;
            numsh <= '0;
            quo   <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                iter  <= IT_W'(NUM_W);
                rem   <= '0;
                numsh <= num;
                quo   <= '0;
            end else if (busy) begin
                rem   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quo   <= {quo[NUM_W-2:0], fits};
                numsh <= numsh << 1;
                iter  <= iter - 1'b1;
                if (iter == IT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: rtl/puf_metrics.sv
// Module: puf_metrics (top)
// Streams pairs of PUF responses through four population-count trees. The
// trees give distance, weight, intersection and union. The counts are summed
// into running totals, and on request the totals are turned into fixed-point
// percentages by one shared sequential divider.
// Assumes: the host stays within MAX_PAIRS pairs per run or accepts
// saturation, and pulses fin only after the last pair has been accumulated.
module puf_metrics
    import puf_metrics_pkg::*;
#(
    parameter int N         = 16,
    parameter int CHUNK     = 4,
    parameter int MAX_PAIRS = 1024,
    parameter int FRAC      = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 in_valid,
    input  logic [N-1:0]                         ref_word,
    input  logic [N-1:0]                         smp_word,
    output logic                                 res_valid,
    output logic [$clog2(N+1)-1:0]               res_hd,
    output logic [$clog2(N+1)-1:0]               res_hw,
    output logic [$clog2(N+1)-1:0]               res_inter,
    output logic [$clog2(N+1)-1:0]               res_union,
    output logic [$clog2(MAX_PAIRS*N+1)-1:0]     sum_hd,
    output logic [$clog2(MAX_PAIRS*N+1)-1:0]     sum_hw,
    output logic [$clog2(MAX_PAIRS*N+1)-1:0]     sum_inter,
    output logic [$clog2(MAX_PAIRS*N+1)-1:0]     sum_union,
    output logic [$clog2(MAX_PAIRS+1)-1:0]       pair_cnt,
    input  logic                                 fin,
    output logic                                 busy,
    output logic                                 done,
    output logic [7+FRAC-1:0]                    hd_pct,
    output logic [7+FRAC-1:0]                    hw_pct,
    output logic [7+FRAC-1:0]                    jac_pct,
    output logic [7+FRAC-1:0]                    rel_pct,
    output logic                                 empty_flag,
    output logic                                 union_zero
);
    localparam int OW      = $clog2(N + 1);
    localparam int ACC_W   = $clog2(MAX_PAIRS * N + 1);
    localparam int CNT_W   = $clog2(MAX_PAIRS + 1);
    localparam int PCT_W   = 7 + FRAC;
    localparam int NUM_W   = ACC_W + 7 + FRAC;
    localparam logic [PCT_W-1:0] FULL_PCT = PCT_W'(100 << FRAC);

    logic [N-1:0]  operand [NUM_TREES];
    logic [OW-1:0] counts  [NUM_TREES];
    logic          v1, v2;

    // Operand for each count tree
    always_comb begin
        operand[IDX_HD]    = ref_word ^ smp_word;
        operand[IDX_HW]    = smp_word;
        operand[IDX_INTER] = ref_word & smp_word;
        operand[IDX_UNION] = ref_word | smp_word;
    end

    for (genvar g = 0; g < NUM_TREES; g++) begin : g_tree
        popcnt_pipe #(.W(N), .CHUNK(CHUNK)) u_pc (
            .clk       (clk),
            .rst_n     (rst_n),
            .bits_in   (operand[g]),
            .count_out (counts[g])
        );
    end

    // Valid pipeline matching the tree latency, flushed by clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
        end
    end

    assign res_valid = v2;
    assign res_hd    = counts[IDX_HD];
    assign res_hw    = counts[IDX_HW];
    assign res_inter = counts[IDX_INTER];
    assign res_union = counts[IDX_UNION];

    // Running totals with saturation at MAX_PAIRS
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_hd    <= '0;
            sum_hw    <= '0;
            sum_inter <= '0;
            sum_union <= '0;
            pair_cnt  <= '0;
        end else if (v2 && pair_cnt < CNT_W'(MAX_PAIRS)) begin
            sum_hd    <= sum_hd    + ACC_W'(res_hd);
            sum_hw    <= sum_hw    + ACC_W'(res_hw);
            sum_inter <= sum_inter + ACC_W'(res_inter);
            sum_union <= sum_union + ACC_W'(res_union);
            pair_cnt  <= pair_cnt + 1'b1;
        end
    end

    // ---------------- finalize sequencer ----------------
    fin_state_t       state;
    logic [1:0]       sel;
    logic [ACC_W-1:0] snap_hd, snap_hw, snap_int, snap_uni, snap_bits;
    logic [ACC_W-1:0] num_sel, den_sel;
    logic [NUM_W-1:0] div_num, div_quo;
    logic             div_busy, div_done, den_zero;

    // Pick the operands of the ratio being computed
    always_comb begin
        case (sel)
            2'd0:    begin num_sel = snap_hd;  den_sel = snap_bits; end
            2'd1:    begin num_sel = snap_hw;  den_sel = snap_bits; end
            default: begin num_sel = snap_int; den_sel = snap_uni;  end
        endcase
        div_num  = (NUM_W'(num_sel) * NUM_W'(100)) << FRAC;
        den_zero = den_sel == '0;
    end

    seq_divider #(.NUM_W(NUM_W), .DEN_W(ACC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == ST_LAUNCH),
        .num   (div_num),
        .den   (den_sel),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    // Snapshot the totals, step through the three ratios, store results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sel        <= '0;
            snap_hd    <= '0;
            snap_hw    <= '0;
            snap_int   <= '0;
            snap_uni   <= '0;
            snap_bits  <= '0;
            hd_pct     <= '0;
            hw_pct     <= '0;
            jac_pct    <= '0;
            empty_flag <= 1'b1;
            union_zero <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (fin) begin
                    snap_hd    <= sum_hd;
                    snap_hw    <= sum_hw;
                    snap_int   <= sum_inter;
                    snap_uni   <= sum_union;
                    snap_bits  <= ACC_W'(pair_cnt) * ACC_W'(N);
                    empty_flag <= pair_cnt == '0;
                    union_zero <= sum_union == '0;
                    sel        <= '0;
                    state      <= ST_LAUNCH;
                end
                ST_LAUNCH: state <= ST_WAIT;
                ST_WAIT: if (div_done) begin
                    case (sel)
                        2'd0:    hd_pct  <= den_zero ? '0 : div_quo[PCT_W-1:0];
                        2'd1:    hw_pct  <= den_zero ? '0 : div_quo[PCT_W-1:0];
                        default: jac_pct <= den_zero ? '0 : div_quo[PCT_W-1:0];
                    endcase
                    if (sel == 2'd2) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        sel   <= sel + 1'b1;
                        state <= ST_LAUNCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = state != ST_IDLE;
    assign rel_pct = empty_flag ? '0 : FULL_PCT - hd_pct;

    // ---------------- assertions ----------------
    assert_hd_from_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hd == res_union - res_inter));

    assert_union_ge_inter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_union >= res_inter));

    assert_sum_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_inter <= sum_union);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_cnt <= CNT_W'(MAX_PAIRS));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pair_cnt == '0 && sum_hd == '0 && sum_union == '0));

    assert_fin_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !busy) |=> busy);

    assert_jac_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && union_zero) |-> (jac_pct == '0));

    assert_rel_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pct <= FULL_PCT);

endmodule

// File: tb/puf_metrics_tb.sv
// Bench for puf_metrics: exhaustive pair sweep plus accumulation,
// saturation, clear and finalize cases, all expected values computed here.
module puf_metrics_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int CHUNK = 4;
    localparam int MAXP  = 6;
    localparam int FRAC  = 4;
    localparam int OW    = $clog2(N + 1);
    localparam int ACC_W = $clog2(MAXP * N + 1);
    localparam int CNT_W = $clog2(MAXP + 1);
    localparam int PCT_W = 7 + FRAC;
    localparam int FULL  = 100 << FRAC;

    logic clk = 1'b0;
    logic rst_n, clr, in_valid, fin;
    logic [N-1:0] ref_word, smp_word;
    logic res_valid, busy, done, empty_flag, union_zero;
    logic [OW-1:0] res_hd, res_hw, res_inter, res_union;
    logic [ACC_W-1:0] sum_hd, sum_hw, sum_inter, sum_union;
    logic [CNT_W-1:0] pair_cnt;
    logic [PCT_W-1:0] hd_pct, hw_pct, jac_pct, rel_pct;

    int checks = 0;
    int fails  = 0;
    int e_hd, e_hw, e_in, e_un, e_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    puf_metrics #(.N(N), .CHUNK(CHUNK), .MAX_PAIRS(MAXP), .FRAC(FRAC)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .ref_word(ref_word), .smp_word(smp_word), .res_valid(res_valid),
        .res_hd(res_hd), .res_hw(res_hw), .res_inter(res_inter), .res_union(res_union),
        .sum_hd(sum_hd), .sum_hw(sum_hw), .sum_inter(sum_inter), .sum_union(sum_union),
        .pair_cnt(pair_cnt), .fin(fin), .busy(busy), .done(done),
        .hd_pct(hd_pct), .hw_pct(hw_pct), .jac_pct(jac_pct), .rel_pct(rel_pct),
        .empty_flag(empty_flag), .union_zero(union_zero)
    );

    function automatic int pop(input logic [N-1:0] w);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(w[i]);
        return c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        e_hd = 0; e_hw = 0; e_in = 0; e_un = 0; e_cnt = 0;
    endtask

    task automatic send(input logic [N-1:0] r, input logic [N-1:0] s);
        @(negedge clk);
        ref_word = r; smp_word = s; in_valid = 1'b1;
        if (e_cnt < MAXP) begin
            e_hd += pop(r ^ s); e_hw += pop(s);
            e_in += pop(r & s); e_un += pop(r | s); e_cnt++;
        end
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic check_sums(input string req);
        repeat (4) @(negedge clk);
        chk({req, " sum_hd"},    int'(sum_hd),    e_hd);
        chk({req, " sum_hw"},    int'(sum_hw),    e_hw);
        chk({req, " sum_inter"}, int'(sum_inter), e_in);
        chk({req, " sum_union"}, int'(sum_union), e_un);
        chk({req, " pair_cnt"},  int'(pair_cnt),  e_cnt);
    endtask

    task automatic finalize_and_check();
        int hd_e, hw_e, jac_e, rel_e;
        @(negedge clk); fin = 1'b1;
        @(negedge clk); fin = 1'b0;
        chk("R7 busy after fin", int'(busy), 1);
        while (busy) @(negedge clk);
        hd_e  = (e_cnt == 0) ? 0 : (e_hd * FULL) / (e_cnt * N);
        hw_e  = (e_cnt == 0) ? 0 : (e_hw * FULL) / (e_cnt * N);
        jac_e = (e_un == 0)  ? 0 : (e_in * FULL) / e_un;
        rel_e = (e_cnt == 0) ? 0 : FULL - hd_e;
        chk("R7 hd_pct",     int'(hd_pct),     hd_e);
        chk("R7 hw_pct",     int'(hw_pct),     hw_e);
        chk("R8 jac_pct",    int'(jac_pct),    jac_e);
        chk("R8 union_zero", int'(union_zero), int'(e_un == 0));
        chk("R9 rel_pct",    int'(rel_pct),    rel_e);
        chk("R9 empty_flag", int'(empty_flag), int'(e_cnt == 0));
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic p1v, p2v;
        logic [N-1:0] p1r, p1s, p2r, p2s;
        rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; fin = 1'b0;
        ref_word = '0; smp_word = '0;
        e_hd = 0; e_hw = 0; e_in = 0; e_un = 0; e_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R4 reset pair_cnt", int'(pair_cnt), 0);
        chk("R4 reset sum_hd", int'(sum_hd), 0);
        chk("R7 reset busy", int'(busy), 0);
        chk("R9 reset empty_flag", int'(empty_flag), 1);
        chk("R9 reset rel_pct", int'(rel_pct), 0);

        // Exhaustive back-to-back sweep, counts checked two edges later
        p1v = 1'b0; p2v = 1'b0; p1r = '0; p1s = '0; p2r = '0; p2s = '0;
        for (int i = 0; i < (1 << (2*N)) + 2; i++) begin
            @(negedge clk);
            chk("R1 res_valid", int'(res_valid), int'(p2v));
            if (p2v) begin
                chk("R1 res_hd",    int'(res_hd),    pop(p2r ^ p2s));
                chk("R2 res_hw",    int'(res_hw),    pop(p2s));
                chk("R3 res_inter", int'(res_inter), pop(p2r & p2s));
                chk("R3 res_union", int'(res_union), pop(p2r | p2s));
            end
            p2v = p1v; p2r = p1r; p2s = p1s;
            if (i < (1 << (2*N))) begin
                p1v = 1'b1;
                p1r = N'(i >> N);
                p1s = N'(i);
                if (e_cnt < MAXP) begin
                    e_hd += pop(p1r ^ p1s); e_hw += pop(p1s);
                    e_in += pop(p1r & p1s); e_un += pop(p1r | p1s); e_cnt++;
                end
            end else begin
                p1v = 1'b0;
            end
            in_valid = p1v; ref_word = p1r; smp_word = p1s;
        end
        // Sweep far exceeded MAX_PAIRS: totals hold the first pairs only
        check_sums("R5 saturated");

        // Mixed pairs, accumulation and ratios
        clear_all();
        check_sums("R6 after clear");
        send(8'hF0, 8'hCC);
        send(8'hFF, 8'h0F);
        send(8'hA5, 8'h5A);
        check_sums("R4 mixed");
        finalize_and_check();

        // Identical responses: full reliability
        clear_all();
        send(8'h3C, 8'h3C);
        send(8'h81, 8'h81);
        check_sums("R4 identical");
        finalize_and_check();

        // Zero union
        clear_all();
        send(8'h00, 8'h00);
        check_sums("R8 zero union");
        finalize_and_check();

        // Empty run
        clear_all();
        finalize_and_check();

        // Clear while a pair is in the count pipeline
        clear_all();
        @(negedge clk);
        ref_word = 8'hFF; smp_word = 8'h00; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check_sums("R6 in-flight discard");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule